// File: doc/BRIEF.md
# Tick-Based Single-Shot, Turn-On Delay and Turn-Off Delay Timer

This block is a single-channel timer for control logic. It watches one Boolean input, counts time in units of a one-cycle time-base tick, and drives a Boolean output together with the accumulated time. An elaboration parameter picks one of three behaviours. In single-shot mode a rising input fires a fixed-length pulse that cannot be retriggered. In turn-on delay mode the output rises only after the input has stayed high for the programmed span. In turn-off delay mode the output follows a rising input at once and falls only after the input has stayed low for the programmed span.

The programmed span is a plain input measured in ticks. The elapsed count advances only on cycles where the tick input is high, and it never goes past the span. The time base is produced outside the block, and the mode is fixed for a given instance. The output and the elapsed count are registered. Both reflect the inputs sampled at the most recent rising clock edge. All pins are plain level signals with no handshake.

Top module: `ptimer`

## Requirements
- R1: Single-shot mode, start. A rising input (high now, low at the previous edge) seen while the timer is idle makes the output true after that edge, with the elapsed count at 0. A tick at the start edge does not advance the count.
- R2: Single-shot mode, no retrigger. While a pulse is running, input edges and input level neither restart nor stop it. The output stays true, and the count keeps advancing on each tick.
- R3: Single-shot mode, end of pulse. At the edge where the count reaches the span, the outcome depends on the input. If the input is high, the output stays true and the count holds at the span until an edge that sees the input low. Once the input is low, the output goes false and the count returns to 0.
- R4: Turn-on delay mode, set. The count advances while the input is high. The output becomes true at the edge where the count reaches the span, and stays true with the count held at the span for as long as the input is high.
- R5: Turn-on delay mode, clear. Any edge that sees the input low clears the count to 0 and the output to false, including an edge before the span has elapsed.
- R6: Turn-off delay mode, basic behaviour. An edge that sees the input high sets the output true and the count to 0. While the input is low and the output is true, the count advances. The output goes false at the edge where the count reaches the span, and the count then holds at the span while the input stays low.
- R7: Turn-off delay mode, restart. If the input goes high again before the span elapses, the count clears to 0 and the output stays true.
- R8: The elapsed count rises by exactly one, and only at an edge where the tick input is high. It saturates at the span. It is never below 0, and it only drops by being cleared to 0.
- R9: A span of 0 makes each delayed transition happen at the first edge that samples the triggering input level. A single-shot pulse then lasts one cycle when the input is low on the following edge.
- R10: A synchronous reset clears the output, the elapsed count, the stored previous input level and the single-shot state. After reset the output is false and the count is 0.
- R11: Every output change becomes visible after the rising clock edge that samples the causing inputs, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base tick, high for one cycle per time unit |
| trig_in | input | 1 | Boolean input being timed |
| span | input | W | Programmed duration in ticks |
| q_out | output | 1 | Timer output |
| elapsed | output | W | Accumulated time in ticks |

## Verification
Every result of this timer is due exactly one rising edge after the cycle whose inputs cause it. The bench drives the input, tick and span on a falling edge. It queues the expected output and count against the cycle number that follows the next rising edge. A monitor pops and compares each expectation on the falling edge of that cycle. Cases where the tick is held low show that the count freezes in the very cycle the tick is absent. Cases with a zero span show that a delayed transition lands on the same edge as its cause.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  // Behaviour selected at elaboration time.
  typedef enum logic [1:0] {
    PT_PULSE     = 2'd0,
    PT_ON_DELAY  = 2'd1,
    PT_OFF_DELAY = 2'd2
  } ptimer_mode_e;

  // States of the single-shot sequencer.
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_RUN  = 2'd1,
    PS_HOLD = 2'd2
  } pulse_state_e;

endpackage

// File: rtl/ptimer_edge.sv
module ptimer_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         reached
);

  logic [W-1:0] cand;

  // The candidate ignores clr, so the controller can use 'reached'
  // to decide on clr without forming a combinational loop.
  always_comb begin
    if (adv && (count < limit)) cand = count + 1'b1;
    else                        cand = count;
  end

  assign reached = (cand >= limit);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (clr) count <= '0;
    else          count <= cand;
  end

endmodule

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
  import ptimer_pkg::*;
#(
  parameter ptimer_mode_e MODE = PT_PULSE
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lvl,
  input  logic rise,
  input  logic reached,
  output logic adv,
  output logic clr,
  output logic q
);

  logic q_n;

  generate
    if (MODE == PT_PULSE) begin : g_pulse
      pulse_state_e st, st_n;

      always_comb begin
        adv  = (st == PS_RUN) & tick;
        clr  = 1'b0;
        st_n = st;
        q_n  = q;
        case (st)
          PS_IDLE: begin
            clr = 1'b1;
            q_n = 1'b0;
            if (rise) begin
              st_n = PS_RUN;
              q_n  = 1'b1;
            end
          end
          PS_RUN: begin
            q_n = 1'b1;
            if (reached) begin
              if (lvl) begin
                st_n = PS_HOLD;
              end else begin
                st_n = PS_IDLE;
                q_n  = 1'b0;
                clr  = 1'b1;
              end
            end
          end
          PS_HOLD: begin
            q_n = 1'b1;
            if (!lvl) begin
              st_n = PS_IDLE;
              q_n  = 1'b0;
              clr  = 1'b1;
            end
          end
          default: begin
            st_n = PS_IDLE;
            q_n  = 1'b0;
            clr  = 1'b1;
          end
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) st <= PS_IDLE;
        else     st <= st_n;
      end
    end else if (MODE == PT_ON_DELAY) begin : g_on
      logic unused_rise;
      assign unused_rise = rise;

      always_comb begin
        adv = lvl & tick;
        clr = ~lvl;
        q_n = lvl & reached;
      end
    end else begin : g_off
      logic unused_rise;
      assign unused_rise = rise;

      always_comb begin
        adv = ~lvl & q & tick;
        clr = lvl;
        q_n = lvl | (q & ~reached);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_n;
  end

endmodule

// File: rtl/ptimer.sv
module ptimer
  import ptimer_pkg::*;
#(
  parameter int           W    = 16,
  parameter ptimer_mode_e MODE = PT_PULSE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         trig_in,
  input  logic [W-1:0] span,
  output logic         q_out,
  output logic [W-1:0] elapsed
);

  logic rise;
  logic adv;
  logic clr;
  logic reached;

  ptimer_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (trig_in),
    .rise (rise)
  );

  ptimer_ctrl #(.MODE(MODE)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .lvl     (trig_in),
    .rise    (rise),
    .reached (reached),
    .adv     (adv),
    .clr     (clr),
    .q       (q_out)
  );

  ptimer_count #(.W(W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .clr     (clr),
    .limit   (span),
    .count   (elapsed),
    .reached (reached)
  );

endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker
  import ptimer_pkg::*;
#(
  parameter int           W    = 16,
  parameter ptimer_mode_e MODE = PT_PULSE
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         trig_in,
  input logic [W-1:0] span,
  input logic         q_out,
  input logic [W-1:0] elapsed
);

  // R10: one edge after reset is seen, output and count are clear
  a_r10_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!q_out && elapsed == '0));

  // R8: a count that moved without clearing needed a tick
  a_r8_tick_gated: assert property (@(posedge clk) disable iff (rst)
    (elapsed != $past(elapsed) && elapsed != '0) |-> $past(tick));

  // R8: the count only climbs by one
  a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
    (elapsed > $past(elapsed)) |-> (elapsed == $past(elapsed) + 1'b1));

  generate
    if (MODE == PT_PULSE) begin : g_pulse_chk
      // R1: a rising input while idle starts a pulse at the next edge
      a_r1_pulse_start: assert property (@(posedge clk) disable iff (rst)
        (trig_in && !$past(trig_in) && !q_out) |=> q_out);
      // R2: a running pulse is not dropped while the count is below the span
      a_r2_no_early_stop: assert property (@(posedge clk) disable iff (rst)
        (q_out && elapsed < span && $stable(span) && !tick) |=> q_out);
    end else if (MODE == PT_ON_DELAY) begin : g_on_chk
      // R5: output only true if input was high at the edge that set it
      a_r5_on_needs_input: assert property (@(posedge clk) disable iff (rst)
        q_out |-> $past(trig_in));
      // R4: output true only with the count at or above the span
      a_r4_on_at_span: assert property (@(posedge clk) disable iff (rst)
        q_out |-> (elapsed >= $past(span)));
    end else begin : g_off_chk
      // R6: a high input is reflected on the output at the next edge
      a_r6_off_follows_high: assert property (@(posedge clk) disable iff (rst)
        $past(trig_in) |-> q_out);
      // R6: the output falls only with the count at the span
      a_r6_off_drop_at_span: assert property (@(posedge clk) disable iff (rst)
        $fell(q_out) |-> (elapsed >= $past(span)));
    end
  endgenerate

endmodule

bind ptimer ptimer_checker #(.W(W), .MODE(MODE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .trig_in (trig_in),
  .span    (span),
  .q_out   (q_out),
  .elapsed (elapsed)
);

// File: tb/ptimer_tb.sv
module ptimer_tb;
  import ptimer_pkg::*;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         trig_in = 1'b0;
  logic [W-1:0] span = '0;

  logic         q_p, q_on, q_off;
  logic [W-1:0] et_p, et_on, et_off;

  int cyc    = 0;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int           due;
    int           mode;
    logic         q;
    logic [W-1:0] et;
    string        tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  ptimer #(.W(W), .MODE(PT_PULSE)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .trig_in(trig_in), .span(span),
    .q_out(q_p), .elapsed(et_p)
  );

  ptimer #(.W(W), .MODE(PT_ON_DELAY)) u_dut_on (
    .clk(clk), .rst(rst), .tick(tick), .trig_in(trig_in), .span(span),
    .q_out(q_on), .elapsed(et_on)
  );

  ptimer #(.W(W), .MODE(PT_OFF_DELAY)) u_dut_off (
    .clk(clk), .rst(rst), .tick(tick), .trig_in(trig_in), .span(span),
    .q_out(q_off), .elapsed(et_off)
  );

  // Monitor: compare every expectation due in this cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      logic         aq;
      logic [W-1:0] aet;
      e = sb.pop_front();
      case (e.mode)
        0:       begin aq = q_p;   aet = et_p;   end
        1:       begin aq = q_on;  aet = et_on;  end
        default: begin aq = q_off; aet = et_off; end
      endcase
      checks++;
      if (e.due != cyc || aq !== e.q || aet !== e.et) begin
        errors++;
        $display("FAIL %s mode=%0d cycle=%0d: q=%b et=%0d, expected q=%b et=%0d",
                 e.tag, e.mode, cyc, aq, aet, e.q, e.et);
      end
    end
  end

  // Driver: apply inputs on a falling edge, result due after the next rising edge.
  task automatic step(input logic i, input logic t, input int p, input int m,
                      input logic eq, input int eet, input string tag);
    exp_t e;
    @(negedge clk);
    trig_in = i;
    tick    = t;
    span    = p[W-1:0];
    e.due   = cyc + 1;
    e.mode  = m;
    e.q     = eq;
    e.et    = eet[W-1:0];
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic do_reset();
    exp_t e;
    @(negedge clk);
    rst     = 1'b1;
    trig_in = 1'b0;
    tick    = 1'b1;
    for (int m = 0; m < 3; m++) begin
      e.due  = cyc + 1;
      e.mode = m;
      e.q    = 1'b0;
      e.et   = '0;
      e.tag  = "R10 reset";
      sb.push_back(e);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);

    // ---- single-shot mode (mode 0), span 3 ----
    do_reset();
    step(1, 1, 3, 0, 1, 0, "R1 start, tick ignored");
    step(0, 1, 3, 0, 1, 1, "R2 input low mid-pulse");
    step(1, 1, 3, 0, 1, 2, "R2 retrigger ignored");
    step(0, 0, 3, 0, 1, 2, "R8 no tick holds count");
    step(0, 1, 3, 0, 0, 0, "R3 expiry with input low");
    step(0, 1, 3, 0, 0, 0, "R3 idle stays off");
    step(1, 1, 3, 0, 1, 0, "R1 second start");
    step(1, 1, 3, 0, 1, 1, "R8 count 1");
    step(1, 1, 3, 0, 1, 2, "R8 count 2");
    step(1, 1, 3, 0, 1, 3, "R3 expiry with input high");
    step(1, 1, 3, 0, 1, 3, "R8 saturates at span");
    step(0, 1, 3, 0, 0, 0, "R3 release after hold");
    step(1, 0, 0, 0, 1, 0, "R9 zero span start");
    step(1, 0, 0, 0, 1, 0, "R9 zero span hold");
    step(0, 0, 0, 0, 0, 0, "R9 zero span release");
    step(1, 0, 0, 0, 1, 0, "R9 one-cycle pulse start");
    step(0, 0, 0, 0, 0, 0, "R9 one-cycle pulse end");

    // ---- turn-on delay mode (mode 1), span 3 ----
    do_reset();
    step(1, 1, 3, 1, 0, 1, "R4 counting");
    step(1, 0, 3, 1, 0, 1, "R8 no tick holds count");
    step(0, 1, 3, 1, 0, 0, "R5 early drop clears");
    step(1, 1, 3, 1, 0, 1, "R4 count 1");
    step(1, 1, 3, 1, 0, 2, "R4 count 2");
    step(1, 1, 3, 1, 1, 3, "R4 output set at span");
    step(1, 1, 3, 1, 1, 3, "R8 saturates at span");
    step(0, 1, 3, 1, 0, 0, "R5 release clears");
    step(1, 0, 0, 1, 1, 0, "R9 zero span immediate");
    step(0, 0, 0, 1, 0, 0, "R5 zero span release");

    // ---- turn-off delay mode (mode 2), span 3 ----
    do_reset();
    step(0, 1, 3, 2, 0, 0, "R6 idle does not count");
    step(1, 1, 3, 2, 1, 0, "R6 high sets output");
    step(0, 1, 3, 2, 1, 1, "R6 low starts count");
    step(0, 0, 3, 2, 1, 1, "R8 no tick holds count");
    step(1, 1, 3, 2, 1, 0, "R7 re-rise clears");
    step(0, 1, 3, 2, 1, 1, "R6 count 1");
    step(0, 1, 3, 2, 1, 2, "R6 count 2");
    step(0, 1, 3, 2, 0, 3, "R6 output drops at span");
    step(0, 1, 3, 2, 0, 3, "R6 count holds after drop");
    step(1, 1, 3, 2, 1, 0, "R6 high again");
    step(0, 0, 0, 2, 0, 0, "R9 zero span immediate drop");
    step(1, 0, 0, 2, 1, 0, "R11 high seen after one edge");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule